// File: doc/BRIEF.md
# Bit-Sliced Arithmetic and Logic Unit with Set-Less-Than

This block is a purely combinational arithmetic and logic unit assembled from identical one-bit slices. Each slice forms the bitwise AND, OR, XOR and NOR of its two operand bits, and it holds a full adder whose second input can be inverted. An eight-way selector, indexed directly by a 3-bit operation code, picks what the slice drives onto its result bit. The adder carries ripple from the lowest slice to the highest.

Subtraction is two's complement. The top operation-code bit inverts every b bit and also feeds the carry-in of the lowest slice. For the set-less-than code, the sum bit of the top slice is routed back into the less-than input of the lowest slice. The less-than inputs of all other slices are held low, so the result is 0 or 1 in bit 0. No correction for signed overflow is applied. A zero flag reports an all-zero result, and the carry out of the top slice is exported. The block has no state, so its outputs follow its inputs with no clock.

Top module: `bitslice_alu`

## Requirements
- R1: Code 000 gives opa AND opb, code 001 gives opa OR opb, code 011 gives opa XOR opb, and code 101 gives NOT (opa OR opb), each bit by bit across the full width.
- R2: Code 010 gives (opa + opb) modulo 2^WIDTH.
- R3: Code 110 gives (opa - opb) modulo 2^WIDTH.
- R4: For every code, carry equals bit WIDTH of the sum opa + (opb XOR {WIDTH{op[2]}}) + op[2], with op[2] being the most significant code bit.
- R5: Code 111 gives result bit 0 equal to bit WIDTH-1 of (opa - opb) modulo 2^WIDTH, with no overflow correction, and result bits WIDTH-1 down to 1 equal to 0.
- R6: Code 100 gives a result of 0 for any operands.
- R7: zero is 1 exactly when all result bits are 0.
- R8: The outputs settle from the current inputs alone, with no clock and no stored state, so a new operand or code is reflected before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| op | input | 3 | Operation code |
| result | output | WIDTH | Selected slice results |
| zero | output | 1 | High when result is all zeros |
| carry | output | 1 | Carry out of the top slice |

## Verification
The bench builds the block at its default width of 32. At that width, the signed boundaries 0x7FFFFFFF and 0x80000000 and the all-ones word can be applied directly. These values show that the set-less-than bit is taken from the raw difference sign, which is wrong when the subtraction overflows, and that the full ripple from bit 0 to bit 31 produces the expected carry. Every code is applied to a table of edge operand pairs and to pseudo-random operands. The results are compared with a reference model that works on whole words.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_XOR  = 3'b011,
        OP_NULL = 3'b100,
        OP_NOR  = 3'b101,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    // bit of the code that inverts b and seeds the carry chain
    localparam int INV_BIT = OP_W - 1;

endpackage

// File: rtl/alu_full_adder.sv
module alu_full_adder (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic half_s;

    always_comb begin
        half_s = x_in ^ y_in;
        s_out  = half_s ^ c_in;
        c_out  = (x_in & y_in) | (half_s & c_in);
    end

endmodule

// File: rtl/alu_sel8.sv
module alu_sel8 #(
    parameter int SEL_W = 3
) (
    input  logic [(1 << SEL_W)-1:0] cand,
    input  logic [SEL_W-1:0]        pick,
    output logic                    chosen
);
    localparam int WAYS = 1 << SEL_W;

    logic [WAYS-1:0] hit;

    // one-hot decode, then OR-reduce: a flat and-or selector
    always_comb begin
        for (int k = 0; k < WAYS; k++) begin
            hit[k] = (pick == k[SEL_W-1:0]) & cand[k];
        end
        chosen = |hit;
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic            a_bit,
    input  logic            b_bit,
    input  logic [OP_W-1:0] op,
    input  logic            less_in,
    input  logic            carry_in,
    output logic            carry_out,
    output logic            sum_bit,
    output logic            res_bit
);
    localparam int WAYS = 1 << OP_W;

    logic            b_adj;
    logic [WAYS-1:0] cand;

    assign b_adj = b_bit ^ op[INV_BIT];

    alu_full_adder u_fa (
        .x_in  (a_bit),
        .y_in  (b_adj),
        .c_in  (carry_in),
        .s_out (sum_bit),
        .c_out (carry_out)
    );

    always_comb begin
        cand          = '0;
        cand[OP_AND]  = a_bit & b_bit;
        cand[OP_OR]   = a_bit | b_bit;
        cand[OP_ADD]  = sum_bit;
        cand[OP_XOR]  = a_bit ^ b_bit;
        cand[OP_NULL] = 1'b0;
        cand[OP_NOR]  = ~(a_bit | b_bit);
        cand[OP_SUB]  = sum_bit;
        cand[OP_SLT]  = less_in;
    end

    alu_sel8 #(.SEL_W(OP_W)) u_sel (
        .cand   (cand),
        .pick   (op),
        .chosen (res_bit)
    );

    always_comb begin
        if (!$isunknown({op, a_bit, b_bit, res_bit})) begin
            if (op == OP_AND)
                AST_SLICE_AND: assert (res_bit == (a_bit & b_bit)); // R1
            if (op == OP_NOR)
                AST_SLICE_NOR: assert (res_bit == !(a_bit | b_bit)); // R1
            if (op == OP_NULL)
                AST_SLICE_NULL: assert (res_bit == 1'b0); // R6
        end
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [OP_W-1:0]  op,
    output logic [WIDTH-1:0] result,
    output logic             zero,
    output logic             carry
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] sums;
    logic             slt_bit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic cin_w;
        logic cout_w;
        logic less_w;

        if (i == 0) begin : g_lo
            assign cin_w  = op[INV_BIT];
            assign less_w = slt_bit;
        end else begin : g_hi
            assign cin_w  = g_slice[i-1].cout_w;
            assign less_w = 1'b0;
        end

        alu_slice u_slice (
            .a_bit     (opa[i]),
            .b_bit     (opb[i]),
            .op        (op),
            .less_in   (less_w),
            .carry_in  (cin_w),
            .carry_out (cout_w),
            .sum_bit   (sums[i]),
            .res_bit   (result[i])
        );
    end

    assign slt_bit = sums[TOP];
    assign carry   = g_slice[TOP].cout_w;
    assign zero    = ~|result;

    always_comb begin
        if (!$isunknown({opa, opb, op, result, sums})) begin
            if (op == OP_ADD)
                AST_ADD_WORD: assert (sums == opa + opb); // R2
            if (op == OP_SUB)
                AST_SUB_WORD: assert (result == opa - opb); // R3
            if (op == OP_SLT)
                AST_SLT_UPPER: assert (result[TOP:1] == '0); // R5
            if (op == OP_NULL)
                AST_NULL_ZERO: assert (zero); // R7
        end
    end

endmodule

// File: tb/bitslice_alu_test.sv
module bitslice_alu_test;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa, opb, result;
    logic [2:0]   op;
    logic         zero, carry;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) uut (
        .opa(opa), .opb(opb), .op(op),
        .result(result), .zero(zero), .carry(carry)
    );

    localparam logic [63:0] PAIRS [14] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'h0000_0001, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h0000_0001},
        {32'h7FFF_FFFF, 32'h0000_0001},
        {32'h7FFF_FFFF, 32'h8000_0000},
        {32'h8000_0000, 32'h7FFF_FFFF},
        {32'h8000_0000, 32'h8000_0000},
        {32'h0000_0005, 32'h0000_0007},
        {32'h0000_0007, 32'h0000_0005},
        {32'hA5A5_5A5A, 32'h0F0F_F0F0},
        {32'h1234_5678, 32'h1234_5678},
        {32'h0000_0000, 32'hFFFF_FFFF}
    };

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b010:  return "R2";
            3'b110:  return "R3";
            3'b111:  return "R5";
            3'b100:  return "R6";
            default: return "R1";
        endcase
    endfunction

    function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [2:0] c);
        logic [W-1:0] d;
        d = a - b;
        case (c)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b011:  return a ^ b;
            3'b100:  return '0;
            3'b101:  return ~(a | b);
            3'b110:  return d;
            default: return {{(W-1){1'b0}}, d[W-1]};
        endcase
    endfunction

    function automatic logic ref_carry(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [2:0] c);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, (c[2] ? ~b : b)} + {{W{1'b0}}, c[2]};
        return s[W];
    endfunction

    task automatic check_all(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
        logic [W-1:0] er;
        logic         ec;
        @(posedge clk);
        opa = a; opb = b; op = c;
        @(negedge clk);
        er = ref_res(a, b, c);
        ec = ref_carry(a, b, c);
        checks += 3;
        if (result !== er) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h result=%h expected=%h", tag_of(c), c, a, b, result, er);
        end
        if (carry !== ec) begin
            errors++;
            $display("FAIL R4 op=%b a=%h b=%h carry=%b expected=%b", c, a, b, carry, ec);
        end
        if (zero !== (er == '0)) begin
            errors++;
            $display("FAIL R7 op=%b a=%h b=%h zero=%b expected=%b", c, a, b, zero, (er == '0));
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; op = 3'b000;
        repeat (3) @(posedge clk);
        // idle inputs during reset: AND of zeros gives 0, zero flag set (R1, R7, R8)
        @(negedge clk);
        checks++;
        if (result !== '0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R7 reset result=%h zero=%b expected=0 zero=1", result, zero);
        end
        rst = 1'b0;

        // table of edge pairs, every code (R1..R7)
        foreach (PAIRS[p]) begin
            for (int c = 0; c < 8; c++) begin
                check_all(PAIRS[p][63:32], PAIRS[p][31:0], c[2:0]);
            end
        end

        // pseudo-random operands, every code
        for (int n = 0; n < 300; n++) begin
            check_all($urandom, $urandom, n[2:0]);
        end

        // R8: inputs changed twice between edges, output follows the latest
        @(posedge clk);
        opa = 32'd10; opb = 32'd3; op = 3'b010;
        #1;
        opb = 32'd20;
        @(negedge clk);
        checks++;
        if (result !== 32'd30) begin
            errors++;
            $display("FAIL R8 result=%h expected=%h", result, 32'd30);
        end

        // R5: overflowing subtraction sets no correction: 0x80000000 - 1 -> 0
        check_all(32'h8000_0000, 32'h0000_0001, 3'b111);
        // R5: -1 < 0 gives 1
        check_all(32'hFFFF_FFFF, 32'h0000_0000, 3'b111);
        // R6: all-ones operands under the null code
        check_all(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b100);
        // R3/R4/R7: equal operands subtract to zero with carry out
        check_all(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
        // R2/R4: full-length ripple
        check_all(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule